// File: doc/BRIEF.md
# SIR Receive Unwrap Filter

This block sits between a slow-infrared UART byte decoder and a receive FIFO. Each decoded byte is presented on `in_valid`/`in_byte`. The block finds frame boundaries using fixed begin and end marker bytes and removes those markers, the escape bytes and any idle filler. It undoes the escaping and forwards only the frame contents: address, control, information and the trailing 16-bit FCS. The FCS is passed through and is not checked.

One payload byte is always held back inside the block. This lets the final byte of a frame carry an end marker (`out_last`) together with the frame's error flags. Two errors are reported. A bad-SIR error means a new begin marker arrived before the frame in progress was closed. A length error means the frame carried more payload bytes than the programmed limit. A 12-bit counter shows how many payload bytes the current frame has delivered so far. A constant word exposes the two marker codes for readback.

Top module: `sir_rx_unwrap`

## Requirements
- R1: `flag_word` reads 16'hC1C0: the begin code 0xC0 in bits [7:0] and the end code 0xC1 in bits [15:8].
- R2: Outside a frame, every byte other than 0xC0 is dropped, including 0xFF filler and 0xC1. Nothing is output for these bytes.
- R3: Inside a frame, any byte other than 0xC0, 0xC1 or an unescaped 0x7D is payload and is forwarded in arrival order. A payload byte appears on `out_byte` with `out_valid` high for one cycle. This happens in the cycle after the next payload byte, or the closing marker, is accepted.
- R4: Inside a frame, 0x7D is discarded and the next byte is forwarded XORed with 0x20. That includes a following 0x7D, which becomes 0x5D.
- R5: When 0xC1 closes a frame, the held final byte is output with `out_last`=1, `err_bad_sir`=0 and the frame's length flag. A frame with no payload produces no output.
- R6: When 0xC0 arrives inside a frame, the held final byte is output with `out_last`=1 and `err_bad_sir`=1. A new frame then starts at once, and its payload is forwarded normally.
- R7: `byte_count` is 0 after reset and becomes 0 on every 0xC0. It increments by one for each payload byte accepted, saturates at 4095, and holds its value after 0xC1.
- R8: If a frame accepts more payload bytes than `max_len`, `err_length`=1 on its last byte. A frame of exactly `max_len` bytes reports 0.
- R9: `out_last` is only high with `out_valid`. `err_bad_sir` and `err_length` are only high with `out_last`.
- R10: A cycle with `in_valid` low changes no frame state, and `out_valid` is low in the following cycle.
- R11: After reset, `out_valid` is 0 and the block is outside a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Decoded byte strobe |
| in_byte | input | 8 | Decoded byte from the UART |
| max_len | input | 12 | Maximum accepted payload bytes per frame |
| flag_word | output | 16 | Constant begin/end marker codes |
| out_valid | output | 1 | Payload byte strobe to the FIFO |
| out_byte | output | 8 | Unescaped payload byte |
| out_last | output | 1 | Final byte of a frame |
| err_bad_sir | output | 1 | Frame closed by a new begin marker |
| err_length | output | 1 | Frame exceeded `max_len` |
| byte_count | output | 12 | Payload bytes accepted in the current frame |

## Verification
The hardest state to reach is counter saturation combined with the length error. It needs a single frame of more than 4095 payload bytes. The stimulus sets `max_len` to 4095 and streams 4100 bytes without gaps. Escape pairs that decode to marker values, a begin marker that interrupts an unclosed frame, and empty frames are each driven as short sequences. The scoreboard expects exactly the bytes that must survive, each with its last and error flags.

// File: rtl/sir_unwrap_pkg.sv
package sir_unwrap_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] BOF_CODE = 8'hC0;
  localparam logic [BYTE_W-1:0] EOF_CODE = 8'hC1;
  localparam logic [BYTE_W-1:0] ESC_CODE = 8'h7D;
  localparam logic [BYTE_W-1:0] ESC_FLIP = 8'h20;

  // Restore a byte that followed the escape code.
  function automatic logic [BYTE_W-1:0] unescape(input logic [BYTE_W-1:0] b,
                                                 input logic esc);
    return esc ? (b ^ ESC_FLIP) : b;
  endfunction
endpackage

// File: rtl/sir_byte_classify.sv
module sir_byte_classify
  import sir_unwrap_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  output logic              is_bof,
  output logic              is_eof,
  output logic              is_esc
);
  assign is_bof = (byte_i == BOF_CODE);
  assign is_eof = (byte_i == EOF_CODE);
  assign is_esc = (byte_i == ESC_CODE);
endmodule

// File: rtl/sir_frame_ctrl.sv
module sir_frame_ctrl
  import sir_unwrap_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              is_bof,
  input  logic              is_eof,
  input  logic              is_esc,
  input  logic [CNT_W-1:0]  max_len,
  output logic              in_frame,
  output logic              data_take,
  output logic [BYTE_W-1:0] data_byte,
  output logic              close_eof,
  output logic              close_bof,
  output logic [CNT_W-1:0]  byte_count,
  output logic              len_err
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic esc_q;
  logic esc_start;

  function automatic logic [CNT_W-1:0] count_step(input logic [CNT_W-1:0] c);
    return (c == CNT_MAX) ? c : c + CNT_W'(1);
  endfunction

  assign close_bof = in_valid && in_frame && is_bof;
  assign close_eof = in_valid && in_frame && is_eof;
  assign esc_start = in_valid && in_frame && is_esc && !esc_q;
  assign data_take = in_valid && in_frame && !is_bof && !is_eof && !esc_start;
  assign data_byte = unescape(in_byte, esc_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame   <= 1'b0;
      esc_q      <= 1'b0;
      byte_count <= '0;
      len_err    <= 1'b0;
    end else if (in_valid) begin
      if (is_bof) begin
        in_frame   <= 1'b1;
        esc_q      <= 1'b0;
        byte_count <= '0;
        len_err    <= 1'b0;
      end else if (close_eof) begin
        in_frame <= 1'b0;
        esc_q    <= 1'b0;
      end else if (esc_start) begin
        esc_q <= 1'b1;
      end else if (data_take) begin
        esc_q      <= 1'b0;
        byte_count <= count_step(byte_count);
        if (byte_count >= max_len) len_err <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sir_hold_stage.sv
module sir_hold_stage
  import sir_unwrap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_take,
  input  logic [BYTE_W-1:0] data_byte,
  input  logic              close_eof,
  input  logic              close_bof,
  input  logic              len_err,
  output logic              hold_pending,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_last,
  output logic              err_bad_sir,
  output logic              err_length
);
  logic [BYTE_W-1:0] hold_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_pending <= 1'b0;
      hold_b       <= '0;
      out_valid    <= 1'b0;
      out_byte     <= '0;
      out_last     <= 1'b0;
      err_bad_sir  <= 1'b0;
      err_length   <= 1'b0;
    end else begin
      out_valid   <= 1'b0;
      out_last    <= 1'b0;
      err_bad_sir <= 1'b0;
      err_length  <= 1'b0;
      if (data_take) begin
        if (hold_pending) begin
          out_valid <= 1'b1;
          out_byte  <= hold_b;
        end
        hold_b       <= data_byte;
        hold_pending <= 1'b1;
      end else if (close_eof || close_bof) begin
        if (hold_pending) begin
          out_valid   <= 1'b1;
          out_byte    <= hold_b;
          out_last    <= 1'b1;
          err_bad_sir <= close_bof;
          err_length  <= len_err;
        end
        hold_pending <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sir_rx_unwrap.sv
module sir_rx_unwrap
  import sir_unwrap_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  input  logic [CNT_W-1:0]  max_len,
  output logic [15:0]       flag_word,
  output logic              out_valid,
  output logic [7:0]        out_byte,
  output logic              out_last,
  output logic              err_bad_sir,
  output logic              err_length,
  output logic [CNT_W-1:0]  byte_count
);
  logic              is_bof, is_eof, is_esc;
  logic              in_frame, data_take, close_eof, close_bof, len_err;
  logic              hold_pending;
  logic [BYTE_W-1:0] data_byte;

  assign flag_word = {EOF_CODE, BOF_CODE};

  sir_byte_classify u_cls (
    .byte_i (in_byte),
    .is_bof (is_bof),
    .is_eof (is_eof),
    .is_esc (is_esc)
  );

  sir_frame_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_byte    (in_byte),
    .is_bof     (is_bof),
    .is_eof     (is_eof),
    .is_esc     (is_esc),
    .max_len    (max_len),
    .in_frame   (in_frame),
    .data_take  (data_take),
    .data_byte  (data_byte),
    .close_eof  (close_eof),
    .close_bof  (close_bof),
    .byte_count (byte_count),
    .len_err    (len_err)
  );

  sir_hold_stage u_hold (
    .clk          (clk),
    .rst_n        (rst_n),
    .data_take    (data_take),
    .data_byte    (data_byte),
    .close_eof    (close_eof),
    .close_bof    (close_bof),
    .len_err      (len_err),
    .hold_pending (hold_pending),
    .out_valid    (out_valid),
    .out_byte     (out_byte),
    .out_last     (out_last),
    .err_bad_sir  (err_bad_sir),
    .err_length   (err_length)
  );
endmodule

// File: rtl/sir_rx_unwrap_chk.sv
module sir_rx_unwrap_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [7:0]       in_byte,
  input logic             in_frame,
  input logic             data_take,
  input logic             close_eof,
  input logic             close_bof,
  input logic             hold_pending,
  input logic             out_valid,
  input logic             out_last,
  input logic             err_bad_sir,
  input logic             err_length,
  input logic [CNT_W-1:0] byte_count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  p_last_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
  p_err_on_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_bad_sir || err_length) |-> out_last);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_outside_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_frame && in_byte != 8'hC0) |=> !out_valid);
  p_count_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_byte == 8'hC0) |=> (byte_count == '0));
  p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_take && byte_count != CNT_MAX) |=> (byte_count == $past(byte_count) + CNT_W'(1)));
  p_eof_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (close_eof && hold_pending) |=> (out_valid && out_last && !err_bad_sir));
  p_bof_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (close_bof && hold_pending) |=> (out_valid && out_last && err_bad_sir));
endmodule

bind sir_rx_unwrap sir_rx_unwrap_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_byte      (in_byte),
  .in_frame     (in_frame),
  .data_take    (data_take),
  .close_eof    (close_eof),
  .close_bof    (close_bof),
  .hold_pending (hold_pending),
  .out_valid    (out_valid),
  .out_last     (out_last),
  .err_bad_sir  (err_bad_sir),
  .err_length   (err_length),
  .byte_count   (byte_count)
);

// File: tb/sir_rx_unwrap_tb_top.sv
module sir_rx_unwrap_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic [11:0] max_len = 12'd100;
  logic [15:0] flag_word;
  logic        out_valid, out_last, err_bad_sir, err_length;
  logic [7:0]  out_byte;
  logic [11:0] byte_count;

  int checks = 0;
  int fails  = 0;

  logic [10:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  sir_rx_unwrap dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .max_len(max_len), .flag_word(flag_word), .out_valid(out_valid),
    .out_byte(out_byte), .out_last(out_last), .err_bad_sir(err_bad_sir),
    .err_length(err_length), .byte_count(byte_count)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic expect_out(input logic [7:0] b, input bit last, input bit bad,
                            input bit len, input string tag);
    exp_q.push_back({b, last, bad, len});
    tag_q.push_back(tag);
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Monitor: compares every produced byte against the scoreboard queue.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2/R3 unexpected output", {21'd0, out_byte, out_last, err_bad_sir, err_length}, 32'd0);
      end else begin
        logic [10:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({out_byte, out_last, err_bad_sir, err_length} == e, t,
              {21'd0, out_byte, out_last, err_bad_sir, err_length}, {21'd0, e});
      end
    end
  end

  initial begin
    repeat (1000000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R11 out_valid after reset", {31'd0, out_valid}, 32'd0);
    check(byte_count == 12'd0, "R7 count after reset", {20'd0, byte_count}, 32'd0);
    check(flag_word == 16'hC1C0, "R1 flag word", {16'd0, flag_word}, 32'h0000C1C0);
    rst_n = 1'b1;
    idle(2);

    // R2 / R11: bytes before any begin marker vanish
    put(8'hFF); put(8'h12); put(8'hC1); put(8'h7D); put(8'h55);
    idle(3);

    // R3, R5: plain frame
    expect_out(8'h11, 0, 0, 0, "R3 frame byte 0");
    expect_out(8'h22, 0, 0, 0, "R3 frame byte 1");
    expect_out(8'h33, 1, 0, 0, "R5 frame last");
    put(8'hFF); put(8'hC0); put(8'h11); put(8'h22); put(8'h33); put(8'hC1);
    idle(3);
    check(byte_count == 12'd3, "R7 count holds after end", {20'd0, byte_count}, 32'd3);

    // R4: escapes that decode to marker and escape values
    expect_out(8'hC0, 0, 0, 0, "R4 escaped begin code");
    expect_out(8'h7D, 0, 0, 0, "R4 escaped escape code");
    expect_out(8'hC1, 1, 0, 0, "R4 escaped end code last");
    put(8'hC0); put(8'h7D); put(8'hE0); put(8'h7D); put(8'h5D); put(8'h7D); put(8'hE1); put(8'hC1);
    idle(3);

    // R6: begin marker inside frame; R10: gaps in between
    expect_out(8'hAA, 0, 0, 0, "R6 first frame byte");
    expect_out(8'hBB, 1, 1, 0, "R6 bad sir last");
    expect_out(8'hCC, 1, 0, 0, "R6 new frame last");
    put(8'hC0); put(8'hAA); idle(2); put(8'hBB); put(8'hC0);
    idle(2);
    check(byte_count == 12'd0, "R7 count cleared by begin", {20'd0, byte_count}, 32'd0);
    put(8'hCC); idle(3);
    check(byte_count == 12'd1, "R10 count stable during idle", {20'd0, byte_count}, 32'd1);
    put(8'hC1); idle(3);

    // R5: empty frames produce nothing
    put(8'hC0); put(8'hC1); put(8'hC0); put(8'hC0); put(8'hC1);
    idle(3);
    check(byte_count == 12'd0, "R5 empty frame count", {20'd0, byte_count}, 32'd0);

    // R8: exactly max_len then one over
    max_len = 12'd3;
    expect_out(8'h01, 0, 0, 0, "R8 exact b0");
    expect_out(8'h02, 0, 0, 0, "R8 exact b1");
    expect_out(8'h03, 1, 0, 0, "R8 exact last no error");
    put(8'hC0); put(8'h01); put(8'h02); put(8'h03); put(8'hC1);
    idle(2);
    expect_out(8'h01, 0, 0, 0, "R8 over b0");
    expect_out(8'h02, 0, 0, 0, "R8 over b1");
    expect_out(8'h03, 0, 0, 0, "R8 over b2");
    expect_out(8'h04, 1, 0, 1, "R8 over last length error");
    put(8'hC0); put(8'h01); put(8'h02); put(8'h03); put(8'h04); put(8'hC1);
    idle(3);

    // R7 saturation with R8 at the top of the range
    max_len = 12'd4095;
    put(8'hC0);
    for (int i = 0; i < 4100; i++) begin
      expect_out(8'h5A, (i == 4099), 0, (i == 4099), "R7 long frame");
      put(8'h5A);
    end
    idle(2);
    check(byte_count == 12'd4095, "R7 count saturates", {20'd0, byte_count}, 32'd4095);
    put(8'hC1);
    idle(4);

    check(exp_q.size() == 0, "R3 all expected bytes delivered", exp_q.size(), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule